// File: doc/BRIEF.md
# Packed Three-Input Bitwise Logic Unit

This block evaluates an arbitrary three-input Boolean function, bit by bit, over three operand slices that arrive packed together with their 8-entry truth table inside a single operand word. For each result bit, the three bits in the same position of the three slices form a 3-bit index, and the truth table entry at that index becomes the result bit. The slice width follows an element-width control: wide elements get wide slices, narrow elements get narrow ones. The narrowest element width has no defined packing and is rejected.

The operation overwrites its destination. The old destination value is an input, and every result bit above the active slice width is copied from it unchanged. The result is registered. A valid pulse on the input produces a valid pulse on the output exactly one clock later. There is no ready signal and no back-pressure: the unit accepts a new word on every cycle, and the consumer must take each result in the cycle it is flagged.

Top module: `ternlog_unit`

## Requirements
- R1: Element width code `in_width` selects the slice width S: 2'b00 (64-bit elements) gives S=16, 2'b01 (32-bit) gives S=8, 2'b10 (16-bit) gives S=2. In the operand word, slice A sits at bits [S-1:0], slice B at [2S-1:S], slice C at [3S-1:2S], and the truth table T at [3S+7:3S].
- R2: For each i < S, result bit i equals T[{A[i], B[i], C[i]}], with A as the most significant index bit.
- R3: With code 2'b00, result bits [15:0] are computed from 16-bit slices.
- R4: With code 2'b01, result bits [7:0] are computed from 8-bit slices.
- R5: With code 2'b10, result bits [1:0] are computed from 2-bit slices.
- R6: Result bits at positions S and above equal the corresponding bits of `in_old`.
- R7: Code 2'b11 (8-bit elements) is illegal. An accepted word with this code raises `out_illegal` for one cycle, one clock later. `out_valid` stays low, and `out_result` keeps its previous value.
- R8: `out_valid` is high in the cycle after an edge where `in_valid` was high with a legal code, and low otherwise.
- R9: Operand bits above position 3S+7 have no effect on the result.
- R10: After reset, `out_valid` and `out_illegal` are low and `out_result` is zero.
- R11: In a cycle that follows no accepted legal word, `out_result` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present this cycle |
| in_width | input | 2 | Element width code |
| in_operand | input | 64 | Packed slices A, B, C and truth table |
| in_old | input | 64 | Old destination value |
| out_valid | output | 1 | Result valid, one cycle after input |
| out_illegal | output | 1 | Illegal width code was accepted |
| out_result | output | 64 | Registered result |

## Verification
The assertions assume that `in_valid`, `in_width` and `in_old` are driven to known values from reset onwards. The latency and upper-bit properties compare outputs against the inputs of the previous cycle through `$past`. The bench drives every input to zero before reset is released. It then changes inputs only on falling edges, so each sampled input is stable and defined at the rising edge. Illegal codes, idle cycles and garbage upper operand bits are applied deliberately, because these are the cases the assertions constrain.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [1:0] {
    EW64 = 2'b00,
    EW32 = 2'b01,
    EW16 = 2'b10,
    EW8  = 2'b11
  } ew_e;

  localparam int IDX_W = 3;
  localparam int TBL_W = 1 << IDX_W;
  localparam int NUM_LEGAL = 3;
endpackage

// File: rtl/tl_unpack.sv
module tl_unpack
  import tl_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int S64 = 16,
  parameter int S32 = 8,
  parameter int S16 = 2,
  localparam int MAX_S = S64
) (
  input  logic [DATA_W-1:0] op,
  input  ew_e               width,
  output logic [MAX_S-1:0]  slice_a,
  output logic [MAX_S-1:0]  slice_b,
  output logic [MAX_S-1:0]  slice_c,
  output logic [TBL_W-1:0]  table_bits,
  output logic [DATA_W-1:0] keep_mask,
  output logic              legal
);
  logic [MAX_S-1:0]  fa [NUM_LEGAL];
  logic [MAX_S-1:0]  fb [NUM_LEGAL];
  logic [MAX_S-1:0]  fc [NUM_LEGAL];
  logic [TBL_W-1:0]  ft [NUM_LEGAL];
  logic [DATA_W-1:0] fm [NUM_LEGAL];

  for (genvar g = 0; g < NUM_LEGAL; g++) begin : g_variant
    localparam int W = (g == 0) ? S64 : (g == 1) ? S32 : S16;
    always_comb begin
      fa[g] = '0;
      fb[g] = '0;
      fc[g] = '0;
      fa[g][W-1:0] = op[W-1:0];
      fb[g][W-1:0] = op[2*W-1:W];
      fc[g][W-1:0] = op[3*W-1:2*W];
      ft[g] = op[3*W +: TBL_W];
      fm[g] = {DATA_W{1'b1}} >> (DATA_W - W);
    end
  end

  always_comb begin
    slice_a    = '0;
    slice_b    = '0;
    slice_c    = '0;
    table_bits = '0;
    keep_mask  = '0;
    legal      = 1'b1;
    case (width)
      EW64: begin
        slice_a = fa[0]; slice_b = fb[0]; slice_c = fc[0];
        table_bits = ft[0]; keep_mask = fm[0];
      end
      EW32: begin
        slice_a = fa[1]; slice_b = fb[1]; slice_c = fc[1];
        table_bits = ft[1]; keep_mask = fm[1];
      end
      EW16: begin
        slice_a = fa[2]; slice_b = fb[2]; slice_c = fc[2];
        table_bits = ft[2]; keep_mask = fm[2];
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/tl_lut_bank.sv
module tl_lut_bank
  import tl_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]     a,
  input  logic [N-1:0]     b,
  input  logic [N-1:0]     c,
  input  logic [TBL_W-1:0] tbl,
  output logic [N-1:0]     y
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [IDX_W-1:0] idx;
    assign idx  = {a[i], b[i], c[i]};
    assign y[i] = tbl[idx];
  end
endmodule

// File: rtl/tl_merge.sv
module tl_merge #(
  parameter int DATA_W = 64,
  parameter int LO_W = 16
) (
  input  logic [LO_W-1:0]   lo,
  input  logic [DATA_W-1:0] old,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] lo_ext;
  always_comb begin
    lo_ext = '0;
    lo_ext[LO_W-1:0] = lo;
  end
  assign y = (lo_ext & mask) | (old & ~mask);
endmodule

// File: rtl/ternlog_unit.sv
module ternlog_unit
  import tl_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int S64 = 16,
  parameter int S32 = 8,
  parameter int S16 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_width,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [DATA_W-1:0] in_old,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [DATA_W-1:0] out_result
);
  localparam int MAX_S = S64;

  logic [MAX_S-1:0]  sa, sb, sc, lut_y;
  logic [TBL_W-1:0]  tbl;
  logic [DATA_W-1:0] mask, merged;
  logic              legal;

  tl_unpack #(
    .DATA_W(DATA_W), .S64(S64), .S32(S32), .S16(S16)
  ) u_unpack (
    .op(in_operand), .width(ew_e'(in_width)),
    .slice_a(sa), .slice_b(sb), .slice_c(sc),
    .table_bits(tbl), .keep_mask(mask), .legal(legal)
  );

  tl_lut_bank #(.N(MAX_S)) u_lut (
    .a(sa), .b(sb), .c(sc), .tbl(tbl), .y(lut_y)
  );

  tl_merge #(.DATA_W(DATA_W), .LO_W(MAX_S)) u_merge (
    .lo(lut_y), .old(in_old), .mask(mask), .y(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid && legal;
      out_illegal <= in_valid && !legal;
      if (in_valid && legal) out_result <= merged;
    end
  end
endmodule

// File: rtl/ternlog_unit_checker.sv
module ternlog_unit_checker #(
  parameter int DATA_W = 64,
  parameter int S64 = 16,
  parameter int S16 = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_width,
  input logic [DATA_W-1:0] in_old,
  input logic              out_valid,
  input logic              out_illegal,
  input logic [DATA_W-1:0] out_result
);
  p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid && (in_width != 2'b11)));

  p_illegal_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal == $past(in_valid && (in_width == 2'b11)));

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));

  p_upper_kept16_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_width) == 2'b10) |->
      out_result[DATA_W-1:S16] == $past(in_old[DATA_W-1:S16]));

  p_upper_kept64_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_width) == 2'b00) |->
      out_result[DATA_W-1:S64] == $past(in_old[DATA_W-1:S64]));
endmodule

bind ternlog_unit ternlog_unit_checker #(
  .DATA_W(DATA_W), .S64(S64), .S16(S16)
) u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_width(in_width),
  .in_old(in_old), .out_valid(out_valid), .out_illegal(out_illegal),
  .out_result(out_result)
);

// File: tb/ternlog_unit_bench.sv
module ternlog_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_width = 2'b00;
  logic [63:0] in_operand = '0;
  logic [63:0] in_old = '0;
  logic        out_valid;
  logic        out_illegal;
  logic [63:0] out_result;

  typedef struct packed {
    logic        v;
    logic        ill;
    logic [63:0] res;
    logic [7:0]  req;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] model_res = '0;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ternlog_unit u_ternlog_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_width(in_width),
    .in_operand(in_operand), .in_old(in_old), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_result(out_result)
  );

  function automatic int slice_of(logic [1:0] w);
    case (w)
      2'b00:   return 16;
      2'b01:   return 8;
      2'b10:   return 2;
      default: return 0;
    endcase
  endfunction

  // R1 R2 R6: reference evaluation
  function automatic logic [63:0] ref_eval(logic [1:0] w, logic [63:0] op,
                                           logic [63:0] old);
    logic [63:0] r = old;
    int s = slice_of(w);
    for (int i = 0; i < s; i++) begin
      int idx;
      idx = {op[i], op[s+i], op[2*s+i]};
      r[i] = op[3*s+idx];
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [1:0] w, logic [63:0] op,
                       logic [63:0] old, logic [7:0] req);
    exp_t e;
    @(negedge clk);
    in_valid = v; in_width = w; in_operand = op; in_old = old;
    e.v = v && (w != 2'b11);
    e.ill = v && (w == 2'b11);
    if (e.v) model_res = ref_eval(w, op, old);
    e.res = model_res;
    e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: scoreboard comparison shortly after each rising edge
  always @(posedge clk) begin
    cycles++;
    #2;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      string tag;
      e = sb_q.pop_front();
      tag = $sformatf("R%0d", e.req);
      check({tag, " out_valid R8"}, {63'd0, out_valid}, {63'd0, e.v});
      check({tag, " out_illegal R7"}, {63'd0, out_illegal}, {63'd0, e.ill});
      check({tag, " out_result"}, out_result, e.res);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 out_illegal", {63'd0, out_illegal}, 64'd0);
    check("R10 out_result", out_result, 64'd0);
    rst_n = 1'b1;

    // R3: 64-bit elements, A=F0F0 B=CCCC C=AAAA, majority table E8
    drive(1, 2'b00, {8'h00, 8'hE8, 16'hAAAA, 16'hCCCC, 16'hF0F0},
          64'h1234_5678_9ABC_DEF0, 3);
    // R3 R2: xor table 96
    drive(1, 2'b00, {8'h00, 8'h96, 16'h1357, 16'h2468, 16'hFFFF},
          64'hFFFF_FFFF_FFFF_FFFF, 3);
    // R4: 32-bit elements, table F0 selects A
    drive(1, 2'b01, {32'h0, 8'hF0, 8'h33, 8'h55, 8'hA5},
          64'hDEAD_BEEF_0BAD_F00D, 4);
    // R4: table CC selects B
    drive(1, 2'b01, {32'h0, 8'hCC, 8'h33, 8'h5A, 8'hA5},
          64'h0, 4);
    // R5: 16-bit elements, table AA selects C
    drive(1, 2'b10, {50'h0, 8'hAA, 2'b10, 2'b01, 2'b11},
          64'hFFFF_0000_FFFF_0000, 5);
    // R9: garbage above the table must not matter
    drive(1, 2'b10, {50'h3_FFFF_FFFF_FFFF, 8'h01, 2'b00, 2'b00, 2'b01},
          64'h5555_5555_5555_5555, 9);
    drive(1, 2'b00, {8'hFF, 8'h80, 16'hFFFF, 16'h00FF, 16'hFFFF},
          64'h0, 9);
    // R11: idle cycles hold the result
    drive(0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 11);
    drive(0, 2'b11, 64'h1, 64'h2, 11);
    // R7: illegal code
    drive(1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 7);
    drive(1, 2'b01, {32'h0, 8'h7F, 24'hFF_00FF}, 64'h0123_4567_89AB_CDEF, 8);
    drive(1, 2'b11, 64'h0, 64'h0, 7);
    // R6 R1: random words across all codes
    for (int k = 0; k < 300; k++) begin
      logic [1:0] w;
      w = 2'($urandom_range(0, 3));
      drive(1'($urandom_range(0, 1)), w, {$urandom, $urandom},
            {$urandom, $urandom}, 6);
    end
    drive(0, 2'b00, 64'h0, 64'h0, 11);
    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // watchdog
  always @(negedge clk) begin
    if (!done && cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule